// File: doc/BRIEF.md
# Word-Marked Source-Synchronous Serializer

This block turns parallel data words into a single serial data line. The data line runs beside a serial clock that the block generates itself. Words enter through a valid/ready handshake. Each word leaves as a frame of W+2 bit times: the W data bits, least significant first, and then two boundary bits. The default is W = 24, so a frame is 26 bit times.

The receiver finds word edges from the clock line alone. During the two boundary bits the serial clock produces no LOW pulse. The boundary bits are chosen so that the data line makes one rising and one falling transition while the clock is held HIGH. A receiver can therefore detect the boundary without a separate frame signal.

The block runs on one internal clock at twice the bit rate, so each bit time has two phases. A direction input selects serializer operation. When it selects the opposite direction, the parallel inputs are gated off and no new word is accepted.

Top module: `ser_wordmark`

## Requirements
- R1: A frame carries bit times 1 to W+2 in that order. Bit time k (1 ≤ k ≤ W) carries `in_data[k-1]`, so bit 1 is the least significant data bit.
- R2: Bit time W+1 carries the inverse of `in_data[W-1]`.
- R3: Bit time W+2 carries `in_data[W-1]`. Read as the value {bit W+2, bit W+1, data}, 0xFFFFFF becomes 0x2FFFFFF and 0x555555 becomes 0x1555555.
- R4: In each of bit times 1 to W, `ser_clk` is LOW in the first phase and HIGH in the second. `ser_dat` changes only together with the falling edge, so it is stable across the rising edge.
- R5: `ser_clk` stays HIGH through both phases of bit times W+1 and W+2. It therefore has no falling edge between the rising edge of bit W and the start of the next frame.
- R6: `in_ready` is high when `dir_ser` is 1 and the block is either idle or in the last phase of bit time W+2. A handshake at a rising edge makes bit time 1 (first phase) appear on the outputs in the following cycle.
- R7: A word offered during the last phase of a frame starts at once, with no idle phase between frames.
- R8: While no frame is in progress, `ser_clk` is HIGH and `ser_dat` holds its last value.
- R9: With `dir_ser` = 0, `in_ready` is low and `in_valid`/`in_data` have no effect. A frame already in progress completes normally.
- R10: A synchronous active-high `rst` makes the block idle, with `ser_clk` HIGH and `ser_dat` LOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| dir_ser | input | 1 | 1 = serializer direction, 0 = parallel inputs gated off |
| in_valid | input | 1 | Parallel word offered |
| in_ready | output | 1 | Block accepts a word at this edge |
| in_data | input | W | Parallel word |
| ser_clk | output | 1 | Serial clock with the boundary LOW pulses omitted |
| ser_dat | output | 1 | Serial data line |

## Verification
Two events can land in the same clock edge: a frame finishing in its last phase and the next word being accepted. The bench provokes this by holding `in_valid` high through a frame and by offering words at random moments. It also flips `dir_ser` in the middle of frames, so that gating meets a frame that is still in progress. A cycle-exact model in the bench predicts `ser_clk`, `ser_dat` and `in_ready` in every cycle. The model checks that the next frame begins with a LOW phase directly after the HIGH boundary, and that a direction change neither cuts a frame short nor starts one.

// File: rtl/ser_wordmark.sv
module ser_wordmark #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dir_ser,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         ser_clk,
  output logic         ser_dat
);
  localparam int FW = W + 2;
  localparam int IW = $clog2(FW);

  logic [FW-1:0] fr;
  logic [IW-1:0] idx;
  logic          ph, busy;

  wire          last = busy && ph && (idx == IW'(FW-1));
  wire [W-1:0]  din  = dir_ser ? in_data : '0;
  wire [FW-1:0] nfr  = {din[W-1], ~din[W-1], din};
  wire [IW-1:0] nidx = idx + 1'b1;

  assign in_ready = dir_ser && (!busy || last);
  wire take = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      idx     <= '0;
      ph      <= 1'b0;
      fr      <= '0;
      ser_clk <= 1'b1;
      ser_dat <= 1'b0;
    end else if (take) begin
      fr      <= nfr;
      busy    <= 1'b1;
      idx     <= '0;
      ph      <= 1'b0;
      ser_clk <= 1'b0;
      ser_dat <= nfr[0];
    end else if (busy) begin
      if (!ph) begin
        ph      <= 1'b1;
        ser_clk <= 1'b1;
      end else if (last) begin
        busy    <= 1'b0;
        ph      <= 1'b0;
      end else begin
        idx     <= nidx;
        ph      <= 1'b0;
        ser_dat <= fr[nidx];
        ser_clk <= (nidx < IW'(W)) ? 1'b0 : 1'b1;
      end
    end
  end

  AST_IDLE_CLK_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> ser_clk); // R8
  AST_IDLE_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && !$past(rst)) |-> $stable(ser_dat)); // R8
  AST_LAUNCH_LOW: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (!ser_clk && busy)); // R6
  AST_BOUNDARY_HIGH: assert property (@(posedge clk) disable iff (rst)
    (busy && idx >= IW'(W)) |-> ser_clk); // R5
  AST_BIT_INV: assert property (@(posedge clk) disable iff (rst)
    (busy && idx == IW'(W)) |-> (ser_dat == ~fr[W-1])); // R2
  AST_BIT_COPY: assert property (@(posedge clk) disable iff (rst)
    (busy && idx == IW'(W+1)) |-> (ser_dat == fr[W-1])); // R3
  AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (busy && ph && idx < IW'(W)) |-> (ser_clk && $stable(ser_dat))); // R4
  AST_NO_GAP: assert property (@(posedge clk) disable iff (rst)
    (last && in_valid && in_ready) |=> (busy && !ser_clk)); // R7
  AST_DIR_BLOCKS_START: assert property (@(posedge clk) disable iff (rst)
    (!dir_ser && !busy) |=> !busy); // R9
endmodule

// File: tb/sim_ser_wordmark.sv
module sim_ser_wordmark;
  localparam int W  = 24;
  localparam int FW = W + 2;

  logic clk = 1'b0, rst = 1'b1, dir_ser = 1'b1, in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_ready, ser_clk, ser_dat;

  ser_wordmark #(.W(W)) u0 (.clk(clk), .rst(rst), .dir_ser(dir_ser), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .ser_clk(ser_clk), .ser_dat(ser_dat));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit m_on = 0, m_busy = 0, m_last = 0, took = 0;
  int m_p = 0;
  logic [FW-1:0] m_fr = '0;

  function automatic logic [FW-1:0] mk(input logic [W-1:0] d);
    return {d[W-1], ~d[W-1], d};
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit rdy;
    int k;
    rdy = dir_ser && (!m_busy || m_p == 2*FW-1);
    if (m_on && !rst) begin
      if (m_busy) begin
        k = m_p / 2;
        if (k >= W) begin
          chk("R5 boundary clock", ser_clk, 1'b1);
          chk(k == W ? "R2 bit W+1" : "R3 bit W+2", ser_dat, m_fr[k]);
        end else begin
          chk("R4 clock phase", ser_clk, 1'(m_p % 2));
          chk("R1 data bit", ser_dat, m_fr[k]);
        end
      end else begin
        chk("R8 idle clock", ser_clk, 1'b1);
        chk("R8 idle data hold", ser_dat, m_last);
      end
      chk(dir_ser ? "R6 ready" : "R9 ready gated", in_ready, rdy);
    end
    if (rst) begin
      m_on = 1; m_busy = 0; m_p = 0; m_last = 0;
    end else if (m_on) begin
      if (rdy && in_valid) begin
        if (m_busy) m_last = m_fr[FW-1];
        m_busy = 1; m_p = 0; m_fr = mk(in_data); took = 1;
      end else if (m_busy) begin
        if (m_p == 2*FW-1) begin m_busy = 0; m_last = m_fr[FW-1]; end
        else m_p++;
      end
    end
  end

  task automatic send(input logic [W-1:0] d, input int maxwait);
    in_valid = 1'b1; in_data = d;
    for (int i = 0; i < maxwait; i++) begin
      @(posedge clk); #1;
      if (took) begin took = 0; in_valid = 1'b0; return; end
    end
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  initial begin
    #200000000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    idle(3);
    @(negedge clk);
    chk("R10 reset clock high", ser_clk, 1'b1);
    chk("R10 reset data low", ser_dat, 1'b0);
    chk("R10 reset ready", in_ready, 1'b1);
    chk("R3 frame 0xFFFFFF", 1'(mk(24'hFFFFFF) == 26'h2FFFFFF), 1'b1);
    chk("R3 frame 0x555555", 1'(mk(24'h555555) == 26'h1555555), 1'b1);
    @(posedge clk); #1; rst = 1'b0;
    idle(4);
    send(24'hFFFFFF, 200);
    send(24'h555555, 200);
    send(24'h800001, 200);
    send(24'h7FFFFE, 200);
    idle(10);
    // R9: direction off, valid held with data, nothing may start
    dir_ser = 1'b0; in_valid = 1'b1; in_data = 24'hA5A5A5;
    idle(30);
    in_valid = 1'b0; dir_ser = 1'b1;
    // R9: direction dropped mid-frame, frame must complete
    send(24'h123456, 200);
    idle(7); dir_ser = 1'b0; idle(80); dir_ser = 1'b1;
    // R7: valid held across several frames, back to back
    for (int i = 0; i < 6; i++) send(W'($urandom), 200);
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 9) == 0) dir_ser = ~dir_ser;
      if ($urandom_range(0, 3) == 0) send(W'($urandom), $urandom_range(1, 120));
      else idle($urandom_range(0, 40));
    end
    dir_ser = 1'b1;
    idle(120);
    rst = 1'b1; idle(2); rst = 1'b0; idle(2);
    send(24'h000001, 200);
    idle(120);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule